// File: doc/BRIEF.md
# Maximum-Value Index Selector

This block looks at a group of unsigned scores and reports the position of the largest one. A packet scheduler uses it to choose which queued entry goes next under a quality-of-service policy: each entry carries a score, and the entry with the best score wins. The block is purely combinational. It has no clock and no reset, and the index follows any change on the score inputs within the same cycle.

The number of inputs (four or eight) and the width of each score are parameters. A third parameter decides what happens when two or more inputs share the largest score: the higher-numbered input wins, or the lower-numbered input wins. By default, the four-input configuration favours the higher position and the eight-input configuration favours the lower position. The datapath is a balanced tree of two-input magnitude comparators. Each comparator steers a multiplexer that forwards the larger score together with the index it came from. The root forwards only the index.

Top module: `maxsel_top`

## Requirements
- R1: `win_index` equals the position k of an input whose score is not smaller than any other score. Input k occupies bits `[k*W +: W]` of `scores`.
- R2: With four inputs of width 8 and scores 28, 58, 19, 37 at positions 0 to 3, `win_index` is 1.
- R3: `win_index` is `$clog2(N)` bits wide: 2 bits for four inputs and 3 bits for eight inputs. Only N = 4 or N = 8 is accepted.
- R4: With TIE_HIGH = 1, when several inputs share the maximum, `win_index` is the highest-numbered of them. TIE_HIGH defaults to 1 when N = 4.
- R5: With TIE_HIGH = 0, when several inputs share the maximum, `win_index` is the lowest-numbered of them. TIE_HIGH defaults to 0 when N = 8.
- R6: When all inputs are equal, `win_index` is N-1 under TIE_HIGH = 1 and 0 under TIE_HIGH = 0.
- R7: Scores compare as unsigned numbers. A score with its top bit set beats any score with that bit clear. This holds at widths 8 and 16.
- R8: The output depends only on the present inputs. It updates without any clock edge, and no state is kept between input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scores | input | N*W | All scores packed side by side; input k sits in bits [k*W +: W] |
| win_index | output | $clog2(N) | Position of the largest score, resolved by the tie rule |

## Verification
The hardest case to reach is a tie for the maximum between two specific positions that lie in different subtrees, while every other input is smaller. Random scores almost never produce this. For eight inputs, the bench therefore builds a directed vector for each of the 28 position pairs: both positions get a shared top score and the others get distinct lower values. It does this under both tie rules. A four-input, four-bit configuration is swept over all 65536 score combinations, so every tie pattern of that size is covered.

// File: rtl/maxsel_pkg.sv
package maxsel_pkg;

    localparam int MAX_W = 64;

    typedef enum logic {
        KEEP_LOWER = 1'b0,
        KEEP_UPPER = 1'b1
    } tie_rule_e;

    function automatic logic prefer_upper(input logic [MAX_W-1:0] lo,
                                          input logic [MAX_W-1:0] hi,
                                          input tie_rule_e rule);
        if (rule == KEEP_UPPER) begin
            return hi >= lo;
        end
        return hi > lo;
    endfunction

    function automatic tie_rule_e rule_from_bit(input logic b);
        return b ? KEEP_UPPER : KEEP_LOWER;
    endfunction

endpackage

// File: rtl/maxsel_node.sv
module maxsel_node #(
    parameter int W = 8,
    parameter maxsel_pkg::tie_rule_e RULE = maxsel_pkg::KEEP_UPPER
) (
    input  logic [W-1:0] lo_val,
    input  logic [W-1:0] hi_val,
    output logic         take_hi,
    output logic [W-1:0] win_val
);
    import maxsel_pkg::*;

    assign take_hi = prefer_upper(MAX_W'(lo_val), MAX_W'(hi_val), RULE);
    assign win_val = take_hi ? hi_val : lo_val;

    always_comb begin
        assert_node_max_R1: assert (win_val >= lo_val && win_val >= hi_val)
            else $error("node forwarded a value below one operand");
        if (lo_val == hi_val) begin
            if (RULE == KEEP_UPPER) begin
                assert_node_tie_up_R4: assert (take_hi == 1'b1)
                    else $error("node tie did not keep upper operand");
            end else begin
                assert_node_tie_low_R5: assert (take_hi == 1'b0)
                    else $error("node tie did not keep lower operand");
            end
        end
    end

endmodule

// File: rtl/maxsel_tree.sv
module maxsel_tree #(
    parameter int   N        = 4,
    parameter int   W        = 8,
    parameter logic TIE_HIGH = 1'b1
) (
    input  logic [N*W-1:0]       scores,
    output logic [W-1:0]         best_val,
    output logic [$clog2(N)-1:0] best_idx
);
    localparam int HALF = N / 2;
    localparam int IW   = $clog2(N);
    localparam maxsel_pkg::tie_rule_e RULE = maxsel_pkg::rule_from_bit(TIE_HIGH);

    generate
        if (N == 2) begin : g_leaf
            logic th;
            maxsel_node #(.W(W), .RULE(RULE)) u_node (
                .lo_val (scores[W-1:0]),
                .hi_val (scores[2*W-1:W]),
                .take_hi(th),
                .win_val(best_val)
            );
            assign best_idx = th;
        end else begin : g_split
            logic [W-1:0]  lo_v;
            logic [W-1:0]  hi_v;
            logic [IW-2:0] lo_i;
            logic [IW-2:0] hi_i;
            logic          th;

            maxsel_tree #(.N(HALF), .W(W), .TIE_HIGH(TIE_HIGH)) u_lo (
                .scores  (scores[HALF*W-1:0]),
                .best_val(lo_v),
                .best_idx(lo_i)
            );
            maxsel_tree #(.N(HALF), .W(W), .TIE_HIGH(TIE_HIGH)) u_hi (
                .scores  (scores[N*W-1:HALF*W]),
                .best_val(hi_v),
                .best_idx(hi_i)
            );
            maxsel_node #(.W(W), .RULE(RULE)) u_node (
                .lo_val (lo_v),
                .hi_val (hi_v),
                .take_hi(th),
                .win_val(best_val)
            );
            assign best_idx = {th, th ? hi_i : lo_i};
        end
    endgenerate

endmodule

// File: rtl/maxsel_top.sv
module maxsel_top #(
    parameter int   N        = 4,
    parameter int   W        = 8,
    parameter logic TIE_HIGH = (N == 4) ? 1'b1 : 1'b0
) (
    input  logic [N*W-1:0]       scores,
    output logic [$clog2(N)-1:0] win_index
);
    localparam int IW = $clog2(N);

    generate
        if (!(N == 4 || N == 8)) begin : g_bad_n
            $error("maxsel_top supports four or eight inputs only");
        end
    endgenerate

    logic [W-1:0] root_val;

    maxsel_tree #(.N(N), .W(W), .TIE_HIGH(TIE_HIGH)) u_tree (
        .scores  (scores),
        .best_val(root_val),
        .best_idx(win_index)
    );

    logic [W-1:0] picked;
    assign picked = scores[win_index*W +: W];

    always_comb begin
        assert_index_range_R3: assert (int'(win_index) < N)
            else $error("index out of range");
        assert_root_match_R1: assert (picked == root_val)
            else $error("index does not point at forwarded value");
        for (int k = 0; k < N; k++) begin
            assert_is_max_R1: assert (picked >= scores[k*W +: W])
                else $error("a larger score exists");
            if (scores[k*W +: W] == picked) begin
                if (TIE_HIGH) begin
                    assert_tie_high_R4: assert (k <= int'(win_index))
                        else $error("higher tied input not chosen");
                end else begin
                    assert_tie_low_R5: assert (k >= int'(win_index))
                        else $error("lower tied input not chosen");
                end
            end
        end
    end

endmodule

// File: tb/maxsel_top_tb.sv
module maxsel_top_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [15:0]  s4;
    logic [1:0]   i4;
    logic [31:0]  s4w8;
    logic [1:0]   i4w8;
    logic [127:0] s8;
    logic [2:0]   i8;
    logic [63:0]  s8h;
    logic [2:0]   i8h;

    maxsel_top #(.N(4), .W(4))  u_dut  (.scores(s4),   .win_index(i4));
    maxsel_top #(.N(4), .W(8))  u_w8   (.scores(s4w8), .win_index(i4w8));
    maxsel_top #(.N(8), .W(16)) u_n8   (.scores(s8),   .win_index(i8));
    maxsel_top #(.N(8), .W(8), .TIE_HIGH(1'b1)) u_n8h (.scores(s8h), .win_index(i8h));

    function automatic logic [15:0] get(input logic [127:0] flat, input int k, input int w);
        logic [127:0] m;
        m = (128'd1 << w) - 128'd1;
        return 16'((flat >> (k * w)) & m);
    endfunction

    function automatic int ref_idx(input logic [127:0] flat, input int n, input int w, input bit th);
        int best = 0;
        logic [15:0] bv = get(flat, 0, w);
        for (int k = 1; k < n; k++) begin
            logic [15:0] v = get(flat, k, w);
            if (v > bv || (th && v == bv)) begin
                best = k;
                bv = v;
            end
        end
        return best;
    endfunction

    function automatic string tag_of(input logic [127:0] flat, input int n, input int w, input bit th);
        int cnt = 0;
        logic [15:0] mx = 0;
        for (int k = 0; k < n; k++) if (get(flat, k, w) > mx) mx = get(flat, k, w);
        for (int k = 0; k < n; k++) if (get(flat, k, w) == mx) cnt++;
        if (cnt == n) return "R6";
        if (cnt > 1) return th ? "R4" : "R5";
        return "R1";
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        #(190000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog got 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] v;
        s4 = '0; s4w8 = '0; s8 = '0; s8h = '0;
        #5;
        // R6 idle: all-zero inputs
        chk("R6", int'(i4), 3);
        chk("R6", int'(i8), 0);
        chk("R6", int'(i8h), 7);
        // R3 output widths
        chk("R3", $bits(i4), 2);
        chk("R3", $bits(i8), 3);

        // R2 worked example
        s4w8 = {8'd37, 8'd19, 8'd58, 8'd28};
        #10 chk("R2", int'(i4w8), 1);
        // R7 unsigned at width 8
        s4w8 = {8'h7F, 8'h01, 8'h80, 8'h7F};
        #10 chk("R7", int'(i4w8), 1);
        // R8 output follows inputs with no clock edge
        s4w8 = {8'h05, 8'hF0, 8'h01, 8'h02};
        #1 chk("R8", int'(i4w8), 2);
        s4w8 = {8'hF1, 8'hF0, 8'h01, 8'h02};
        #1 chk("R8", int'(i4w8), 3);

        // R1 R4 R6 exhaustive sweep, four inputs of four bits
        for (int a = 0; a < 65536; a++) begin
            s4 = 16'(a);
            #10;
            v = 128'(s4);
            chk(tag_of(v, 4, 4, 1'b1), int'(i4), ref_idx(v, 4, 4, 1'b1));
        end

        // R7 unsigned at width 16
        s8 = '0;
        s8[5*16 +: 16] = 16'h8000;
        s8[2*16 +: 16] = 16'h7FFF;
        #10 chk("R7", int'(i8), 5);

        // R1 random vectors, eight inputs
        for (int r = 0; r < 200; r++) begin
            s8 = {$urandom, $urandom, $urandom, $urandom};
            s8h = {$urandom, $urandom};
            #10;
            chk(tag_of(s8, 8, 16, 1'b0), int'(i8), ref_idx(s8, 8, 16, 1'b0));
            v = 128'(s8h);
            chk(tag_of(v, 8, 8, 1'b1), int'(i8h), ref_idx(v, 8, 8, 1'b1));
        end

        // R4 R5 a tie between every pair of positions
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                s8 = '0;
                s8h = '0;
                for (int k = 0; k < 8; k++) begin
                    s8[k*16 +: 16] = 16'(100 + k);
                    s8h[k*8 +: 8] = 8'(10 + k);
                end
                s8[i*16 +: 16] = 16'hBEEF;
                s8[j*16 +: 16] = 16'hBEEF;
                s8h[i*8 +: 8] = 8'hC3;
                s8h[j*8 +: 8] = 8'hC3;
                #10;
                chk("R5", int'(i8), i);
                chk("R4", int'(i8h), j);
            end
        end

        // R6 all equal nonzero
        s8 = {8{16'h1234}};
        s8h = {8{8'hAA}};
        s4 = {4{4'h9}};
        #10;
        chk("R6", int'(i8), 0);
        chk("R6", int'(i8h), 7);
        chk("R6", int'(i4), 3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule